// File: doc/BRIEF.md
# Multi-Channel PWM with Guarded Emergency Stop

This block produces several independent edge-aligned pulse-width outputs. Each channel has its own up-counter, a period value and a duty value. A shared clock-enable input paces every counter. An output is high while its counter is below the duty value. The counter returns to zero after it reaches the period value, so one cycle of the waveform lasts period+1 enabled ticks.

An external emergency-stop input passes through a two-flop synchroniser. Its active level is chosen by a configuration input. While the stop is active, every enabled channel drives its own programmable safe level. Leaving that state takes two steps: the stop input must first go inactive, and then a restart strobe must arrive. Even after restart, a channel keeps driving its safe level until its own counter next wraps to zero. Each waveform therefore resumes at the start of a period, and no shortened pulse reaches the pins. A status output shows the halted state. An optional one-cycle interrupt pulse marks entry into it.

Top module: `pwm_guarded`

## Requirements
- R1: During and right after reset, haltStatus and haltIrq are 0 and every counter is 0. An enabled, unhalted channel therefore outputs 1 exactly when its duty value is nonzero.
- R2: An enabled channel's counter advances by one on each clock where tickEn is 1 and holds when tickEn is 0. On a tick where the count is at or above the period value, the counter goes to 0 instead. The output is 1 while count < duty.
- R3: A channel whose enable is 0 drives 0, and its counter and its resume-pending flag are cleared.
- R4: The stop input is active when its synchronised value equals killActiveHigh. With killActiveHigh = 0, a low input halts the block, and a steadily high input allows a restart that stays in effect.
- R5: haltStatus rises on the third rising clock edge after the stop input becomes active. While haltStatus is 1, every enabled channel outputs its safeLevel bit.
- R6: A restartWr pulse seen while the synchronised stop input is still active has no effect: haltStatus stays 1.
- R7: restartWr while halted, with the synchronised input inactive, clears haltStatus on that clock edge. It also sets the resume-pending flag of every enabled channel. A pending channel keeps its safeLevel until its counter wraps to 0, then follows the normal duty comparison.
- R8: When irqEnable is 1, haltIrq is high for exactly the one cycle in which haltStatus first becomes 1, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counter advance enable, shared by all channels |
| chEnable | input | NUM_CH | Per-channel enable |
| chPeriod | input | NUM_CH*CNT_W | Packed period values, channel 0 in the low bits |
| chDuty | input | NUM_CH*CNT_W | Packed duty values, channel 0 in the low bits |
| safeLevel | input | NUM_CH | Level each channel drives while stopped or resume-pending |
| killIn | input | 1 | Asynchronous emergency-stop input |
| killActiveHigh | input | 1 | 1: stop is active high; 0: stop is active low |
| restartWr | input | 1 | One-cycle restart request |
| irqEnable | input | 1 | Enables the halt-entry interrupt pulse |
| pwmOut | output | NUM_CH | Channel outputs |
| haltStatus | output | 1 | 1 while the block is halted |
| haltIrq | output | 1 | One-cycle pulse on halt entry |

## Verification
The assertions assume that chEnable and safeLevel are driven from synchronous logic. They also assume that restartWr is a clean synchronous strobe. The one exception is killIn, which the block resynchronises itself. The resume check compares against enables held over two cycles, so a channel switched on in the very cycle of restart is not held to the safe level.

The stimulus drives every input at the falling edge and samples just after it. Only killIn changes at arbitrary cycles. Enables, periods, duties and safe levels change rarely and at random, which covers channels that are reconfigured while resume is still pending.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } guardState_t;

  // strobes from control to the channel datapath
  typedef struct packed {
    logic forceSafe;  // block is halted: drive safe level
    logic armResume;  // restart accepted this cycle: set pending flags
  } guardStrobe_t;

endpackage

// File: rtl/pwm_guard_ctrl.sv
module pwm_guard_ctrl
  import pwm_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         killIn,
  input  logic         killActiveHigh,
  input  logic         restartWr,
  input  logic         irqEnable,
  output guardStrobe_t strobe,
  output logic         killActive,
  output logic         haltStatus,
  output logic         haltIrq
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  guardState_t   state, stateNext;
  logic          resumeGo;
  logic          irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[LAST-1:0], killIn};
  end

  assign killActive = (syncQ[LAST] == killActiveHigh);
  assign resumeGo   = (state == ST_HALT) && restartWr && !killActive;

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:  if (killActive) stateNext = ST_HALT;
      ST_HALT: if (resumeGo)   stateNext = ST_RUN;
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
      irqQ  <= 1'b0;
    end else begin
      state <= stateNext;
      irqQ  <= irqEnable && (state == ST_RUN) && killActive;
    end
  end

  assign strobe.forceSafe = (state == ST_HALT);
  assign strobe.armResume = resumeGo;
  assign haltStatus       = (state == ST_HALT);
  assign haltIrq          = irqQ;

endmodule

// File: rtl/pwm_guard_chan.sv
module pwm_guard_chan
  import pwm_guard_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             enable,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic             safeLevel,
  input  guardStrobe_t     strobe,
  output logic             pwmOut
);

  logic [CNT_W-1:0] count;
  logic             resumePending;
  logic             wrapNow;

  assign wrapNow = tickEn && (count >= period);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        count <= '0;
    else if (!enable) count <= '0;
    else if (wrapNow) count <= '0;
    else if (tickEn)  count <= count + 1'b1;
  end

  // arming wins over a wrap in the same cycle: wait for the next one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 resumePending <= 1'b0;
    else if (!enable)          resumePending <= 1'b0;
    else if (strobe.armResume) resumePending <= 1'b1;
    else if (wrapNow)          resumePending <= 1'b0;
  end

  always_comb begin
    if (!enable)                               pwmOut = 1'b0;
    else if (strobe.forceSafe || resumePending) pwmOut = safeLevel;
    else                                       pwmOut = (count < duty);
  end

endmodule

// File: rtl/pwm_guard_datapath.sv
module pwm_guard_datapath
  import pwm_guard_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tickEn,
  input  logic [NUM_CH-1:0]       chEnable,
  input  logic [NUM_CH*CNT_W-1:0] chPeriod,
  input  logic [NUM_CH*CNT_W-1:0] chDuty,
  input  logic [NUM_CH-1:0]       safeLevel,
  input  guardStrobe_t            strobe,
  output logic [NUM_CH-1:0]       pwmOut
);

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    pwm_guard_chan #(.CNT_W(CNT_W)) uChan (
      .clk       (clk),
      .rstN      (rstN),
      .tickEn    (tickEn),
      .enable    (chEnable[g]),
      .period    (chPeriod[g*CNT_W +: CNT_W]),
      .duty      (chDuty[g*CNT_W +: CNT_W]),
      .safeLevel (safeLevel[g]),
      .strobe    (strobe),
      .pwmOut    (pwmOut[g])
    );
  end

endmodule

// File: rtl/pwm_guarded.sv
module pwm_guarded
  import pwm_guard_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tickEn,
  input  logic [NUM_CH-1:0]       chEnable,
  input  logic [NUM_CH*CNT_W-1:0] chPeriod,
  input  logic [NUM_CH*CNT_W-1:0] chDuty,
  input  logic [NUM_CH-1:0]       safeLevel,
  input  logic                    killIn,
  input  logic                    killActiveHigh,
  input  logic                    restartWr,
  input  logic                    irqEnable,
  output logic [NUM_CH-1:0]       pwmOut,
  output logic                    haltStatus,
  output logic                    haltIrq
);

  guardStrobe_t strobe;
  logic         killActive;

  pwm_guard_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .killIn         (killIn),
    .killActiveHigh (killActiveHigh),
    .restartWr      (restartWr),
    .irqEnable      (irqEnable),
    .strobe         (strobe),
    .killActive     (killActive),
    .haltStatus     (haltStatus),
    .haltIrq        (haltIrq)
  );

  pwm_guard_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .chEnable  (chEnable),
    .chPeriod  (chPeriod),
    .chDuty    (chDuty),
    .safeLevel (safeLevel),
    .strobe    (strobe),
    .pwmOut    (pwmOut)
  );

endmodule

// File: rtl/pwm_guarded_chk.sv
module pwm_guarded_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chEnable,
  input logic [NUM_CH-1:0] safeLevel,
  input logic              restartWr,
  input logic              killActive,
  input logic [NUM_CH-1:0] pwmOut,
  input logic              haltStatus,
  input logic              haltIrq
);

  // R3
  off_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwmOut & ~chEnable) == '0);

  // R5
  halt_safe_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltStatus |-> ((pwmOut ^ safeLevel) & chEnable) == '0);

  // R6
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haltStatus && killActive) |=> haltStatus);

  // R7
  leave_needs_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(haltStatus) |-> $past(restartWr));

  // R7
  resume_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(haltStatus) |-> ((pwmOut ^ safeLevel) & chEnable & $past(chEnable)) == '0);

  // R8
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltIrq |-> (haltStatus && !$past(haltStatus)));

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltIrq |=> !haltIrq);

endmodule

bind pwm_guarded pwm_guarded_chk #(.NUM_CH(NUM_CH)) uChk (.*);

// File: tb/sim_pwm_guarded.sv
`timescale 1ns/1ps
module sim_pwm_guarded;

  localparam int NCH = 4;
  localparam int CW  = 8;

  logic            clk = 1'b0;
  logic            rstN;
  logic            tickEn;
  logic [NCH-1:0]  chEnable;
  logic [NCH*CW-1:0] chPeriod;
  logic [NCH*CW-1:0] chDuty;
  logic [NCH-1:0]  safeLevel;
  logic            killIn;
  logic            killActiveHigh;
  logic            restartWr;
  logic            irqEnable;
  logic [NCH-1:0]  pwmOut;
  logic            haltStatus;
  logic            haltIrq;

  always #2 clk = ~clk;

  pwm_guarded #(.NUM_CH(NCH), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .chEnable(chEnable),
    .chPeriod(chPeriod), .chDuty(chDuty), .safeLevel(safeLevel),
    .killIn(killIn), .killActiveHigh(killActiveHigh), .restartWr(restartWr),
    .irqEnable(irqEnable), .pwmOut(pwmOut), .haltStatus(haltStatus),
    .haltIrq(haltIrq)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // reference model written from the requirements
  logic          mS1, mS2, mHalt, mIrq, mAct, mArm;
  logic [CW-1:0] mCnt  [NCH];
  logic          mPend [NCH];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= 1'b0; mS2 <= 1'b0; mHalt <= 1'b0; mIrq <= 1'b0;
      for (int c = 0; c < NCH; c++) begin mCnt[c] <= '0; mPend[c] <= 1'b0; end
    end else begin
      mAct = (mS2 == killActiveHigh);
      mArm = mHalt && restartWr && !mAct;
      mS1 <= killIn;
      mS2 <= mS1;
      mIrq <= irqEnable && !mHalt && mAct;
      if (!mHalt) mHalt <= mAct;
      else if (mArm) mHalt <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        if (!chEnable[c]) begin
          mCnt[c] <= '0; mPend[c] <= 1'b0;
        end else begin
          if (tickEn) mCnt[c] <= (mCnt[c] >= chPeriod[c*CW +: CW]) ? '0 : mCnt[c] + 1'b1;
          if (mArm) mPend[c] <= 1'b1;
          else if (tickEn && mCnt[c] >= chPeriod[c*CW +: CW]) mPend[c] <= 1'b0;
        end
      end
    end
  end

  // lockstep comparison just after each falling edge
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      for (int c = 0; c < NCH; c++) begin
        logic e;
        if (!chEnable[c]) begin
          chk("R3 off channel", pwmOut[c], 1'b0);
        end else if (mHalt) begin
          chk("R5 halted level", pwmOut[c], safeLevel[c]);
        end else if (mPend[c]) begin
          chk("R7 resume pending", pwmOut[c], safeLevel[c]);
        end else begin
          e = (mCnt[c] < chDuty[c*CW +: CW]);
          chk("R2 duty compare", pwmOut[c], e);
        end
      end
      chk("R5 halt status", haltStatus, mHalt);
      chk("R8 irq pulse", haltIrq, mIrq);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseRestart();
    restartWr = 1'b1;
    @(negedge clk);
    restartWr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; tickEn = 1'b1; restartWr = 1'b0; irqEnable = 1'b1;
    killIn = 1'b0; killActiveHigh = 1'b1;
    chEnable  = 4'b1111;
    chPeriod  = {8'd9, 8'd3, 8'd7, 8'd5};
    chDuty    = {8'd5, 8'd4, 8'd0, 8'd2};
    safeLevel = 4'b1010;
    cyc(3);
    // R1 reset state: counters zero, so outputs follow duty != 0
    chk("R1 reset out", pwmOut, 4'b1101);
    chk("R1 reset halt", haltStatus, 1'b0);
    chk("R1 reset irq", haltIrq, 1'b0);
    rstN = 1'b1;
    cyc(30);

    // R5 / R8: halt entry latency and irq
    killIn = 1'b1;
    cyc(1); chk("R5 latency edge1", haltStatus, 1'b0);
    cyc(1); chk("R5 latency edge2", haltStatus, 1'b0);
    cyc(1); chk("R5 latency edge3", haltStatus, 1'b1);
    chk("R8 irq on entry", haltIrq, 1'b1);
    chk("R5 safe outputs", pwmOut, safeLevel);
    cyc(1); chk("R8 irq one cycle", haltIrq, 1'b0);

    // R6: restart while still active is ignored
    pulseRestart();
    chk("R6 restart ignored", haltStatus, 1'b1);
    cyc(10);
    chk("R6 still halted", haltStatus, 1'b1);

    // R7: release, then restart
    killIn = 1'b0;
    cyc(4);
    chk("R7 halted until restart", haltStatus, 1'b1);
    pulseRestart();
    chk("R7 restart clears halt", haltStatus, 1'b0);
    chk("R7 safe held after restart", pwmOut, safeLevel);
    cyc(40);

    // R4: active-low polarity
    killActiveHigh = 1'b0; killIn = 1'b1;
    cyc(6);
    pulseRestart();
    chk("R4 inactive high input restarts", haltStatus, 1'b0);
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      chk("R4 stays running", haltStatus, 1'b0);
    end
    killIn = 1'b0;
    cyc(3);
    chk("R4 low input halts", haltStatus, 1'b1);
    killIn = 1'b1;
    cyc(4);
    pulseRestart();
    cyc(20);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      tickEn    = ($urandom % 4) != 0;
      restartWr = ($urandom % 16) == 0;
      if ($urandom % 150 == 0) killIn = ~killIn;
      if ($urandom % 500 == 0) killActiveHigh = ~killActiveHigh;
      if ($urandom % 300 == 0) irqEnable = ~irqEnable;
      if ($urandom % 250 == 0) safeLevel = NCH'($urandom);
      if ($urandom % 120 == 0) begin
        int c;
        int p;
        c = int'($urandom % NCH);
        p = int'($urandom % 16) + 1;
        chPeriod[c*CW +: CW] = CW'(p);
        chDuty[c*CW +: CW]   = CW'($urandom % (p + 3));
        if ($urandom % 3 == 0) chEnable[c] = ~chEnable[c];
      end
      cyc(1);
    end
    restartWr = 1'b0;
    cyc(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule